// File: doc/BRIEF.md
# Hash Offload Command Register Block

This block is the software-facing register file of a hash offload engine. A bus master writes 32-bit words to hold a source address, a destination address, a key buffer address, a source length and a command word. A write to the command word is decoded into an algorithm, a scatter-gather flag and an accumulate flag. If the encoding is legal and the engine is idle, a one-cycle start pulse goes to the hashing datapath. The datapath itself sits outside this block and answers with a done pulse.

When the engine completes, a completion flag is set in the status word whether or not interrupts are enabled. The single interrupt line rises only if the command that started the run asked for it. Software clears the flag by writing a one to it, which also drops the interrupt. Reads return data in the same cycle. Addresses outside the register window read as zero and cannot be written.

Top module: `hash_cmd_regs`

## Requirements
- R1: Registers sit at byte offsets cipher command 0x10, status 0x1C, source 0x20, destination 0x24, key 0x28, length 0x2C and command 0x30. A read returns the stored value combinationally in the same cycle. A write to the cipher command word is stored and never starts the engine.
- R2: Stored values are masked: command with 0x00147FFF, source with 0x7FFFFFFF, destination and key with 0x7FFFFFF8, and length with 0x0FFFFFFF. The source, destination, key and length values are also driven on the output ports.
- R3: The family field is command bits [6:4] and the variant field is bits [12:10]. The algorithm output codes are: MD5=0 (family 000), SHA-1=1 (010), SHA-224=2 (100) and SHA-256=3 (101), each with variant 000. The 512-bit family (110) gives SHA-512=4 (variant 000), SHA-384=5 (001), SHA-512/256=6 (010) and SHA-512/224=7 (011).
- R4: Any other family/variant pair is illegal. An illegal command produces no start pulse, but the masked command is still stored and read back.
- R5: The accumulate output is 1 only when command bits [8:7] equal 10. The scatter-gather output equals command bit 18. Both are presented together with the start pulse.
- R6: A legal command written while idle produces a start pulse that is high for exactly the one cycle after the write edge. The engine is busy from that edge until a done pulse. A command written while busy is stored but produces no start pulse.
- R7: A done pulse while busy sets status bit 9 and returns the engine to idle. The interrupt rises on the same edge only if command bit 9 was set in the started command. A done pulse while idle has no effect.
- R8: Writing status with bit 9 set clears the completion flag and lowers the interrupt. Writing status with bit 9 clear changes nothing. If a done pulse and a clearing write land on the same edge, the flag stays set. The other status bits read zero.
- R9: Writes at byte addresses at or above 0x34 are ignored, and reads there return zero. Words inside the window with no register read zero.
- R10: Reset clears every register and the completion flag, deasserts the interrupt and the start pulse, and leaves the engine idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for one word |
| busAddr | input | 12 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| engDone | input | 1 | Completion pulse from the hash datapath |
| engStart | output | 1 | One-cycle start pulse to the datapath |
| engAlgo | output | 3 | Decoded algorithm code (R3) |
| engSgEn | output | 1 | Scatter-gather mode for the started run |
| engAccum | output | 1 | Accumulate mode for the started run |
| srcAddr | output | 32 | Masked source address |
| dstAddr | output | 32 | Masked destination address |
| keyAddr | output | 32 | Masked key buffer address |
| srcLen | output | 32 | Masked source length |
| irqOut | output | 1 | Completion interrupt |

## Verification
Read data is combinational, so it is sampled one time step after the address is set at a falling edge. Each register write lands on the next rising edge. The start pulse and its algorithm and mode outputs are sampled at the falling edge right after the write edge, and the start pulse is checked again one cycle later to confirm it is low. Status and interrupt change on the edge that samples the done pulse and are read at the falling edge that follows. Inputs are always driven at falling edges, so no check depends on process order at a rising edge.

// File: rtl/hashctl_pkg.sv
package hashctl_pkg;
  typedef enum logic [2:0] {
    ALG_MD5        = 3'd0,
    ALG_SHA1       = 3'd1,
    ALG_SHA224     = 3'd2,
    ALG_SHA256     = 3'd3,
    ALG_SHA512     = 3'd4,
    ALG_SHA384     = 3'd5,
    ALG_SHA512T256 = 3'd6,
    ALG_SHA512T224 = 3'd7
  } hashAlgo_e;

  // Write strobes and the command fields the control needs.
  typedef struct packed {
    logic       cmdWr;
    logic       doneClr;
    logic [2:0] family;
    logic [2:0] variant;
    logic [1:0] mode;
    logic       irqEn;
    logic       sgEn;
  } ctlStrobe_t;

  localparam int NUM_REGS   = 6;
  localparam int IDX_CIPHER = 0;
  localparam int IDX_SRC    = 1;
  localparam int IDX_DST    = 2;
  localparam int IDX_KEY    = 3;
  localparam int IDX_LEN    = 4;
  localparam int IDX_CMD    = 5;

  localparam logic [7:0]  REG_OFS  [NUM_REGS] = '{8'h10, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30};
  localparam logic [31:0] REG_MASK [NUM_REGS] = '{32'hFFFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFF8,
                                                  32'h7FFFFFF8, 32'h0FFFFFFF, 32'h00147FFF};
  localparam logic [7:0]  STATUS_OFS = 8'h1C;
  localparam int          DONE_BIT   = 9;
  localparam int          IRQEN_BIT  = 9;
  localparam int          SG_BIT     = 18;
endpackage

// File: rtl/hashctl_regs.sv
module hashctl_regs
  import hashctl_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int REG_W        = 32,
  parameter int WINDOW_BYTES = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              doneFlag,
  output ctlStrobe_t        strobe,
  output logic [REG_W-1:0]  srcAddr,
  output logic [REG_W-1:0]  dstAddr,
  output logic [REG_W-1:0]  keyAddr,
  output logic [REG_W-1:0]  srcLen
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   wordIdx;
  logic                inWindow;
  logic [NUM_REGS-1:0] wrHit;
  logic                statusHit;
  logic [REG_W-1:0]    regQ [NUM_REGS];

  assign wordIdx   = busAddr[ADDR_W-1:2];
  assign inWindow  = busAddr < ADDR_W'(WINDOW_BYTES);
  assign statusHit = inWindow && (wordIdx == WORD_W'(STATUS_OFS >> 2));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign wrHit[i] = busWrEn && inWindow && (wordIdx == WORD_W'(REG_OFS[i] >> 2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wrHit[i]) regQ[i] <= busWdata & REG_MASK[i][REG_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (inWindow && wordIdx == WORD_W'(REG_OFS[i] >> 2)) busRdata = regQ[i];
    if (statusHit) busRdata[DONE_BIT] = doneFlag;
  end

  always_comb begin
    strobe.cmdWr   = wrHit[IDX_CMD];
    strobe.doneClr = busWrEn && statusHit && busWdata[DONE_BIT];
    strobe.family  = busWdata[6:4];
    strobe.variant = busWdata[12:10];
    strobe.mode    = busWdata[8:7];
    strobe.irqEn   = busWdata[IRQEN_BIT];
    strobe.sgEn    = busWdata[SG_BIT];
  end

  assign srcAddr = regQ[IDX_SRC];
  assign dstAddr = regQ[IDX_DST];
  assign keyAddr = regQ[IDX_KEY];
  assign srcLen  = regQ[IDX_LEN];

  // R9: a write outside the window must leave every register untouched
  assert_oow_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr >= ADDR_W'(WINDOW_BYTES)) |=>
      $stable(srcAddr) && $stable(dstAddr) && $stable(keyAddr) && $stable(srcLen));

  // R9: reads outside the window return zero
  assert_oow_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= ADDR_W'(WINDOW_BYTES)) |-> busRdata == '0);
endmodule

// File: rtl/hashctl_ctrl.sv
module hashctl_ctrl
  import hashctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       engDone,
  output logic       engStart,
  output logic [2:0] engAlgo,
  output logic       engSgEn,
  output logic       engAccum,
  output logic       doneFlag,
  output logic       irqOut
);
  logic      busyQ, startQ, sgQ, accQ, irqEnQ, doneQ, irqQ;
  hashAlgo_e algoQ, decAlgo;
  logic      cmdValid;
  logic      finish;

  always_comb begin
    cmdValid = 1'b1;
    decAlgo  = ALG_MD5;
    unique case ({strobe.variant, strobe.family})
      6'b000_000: decAlgo = ALG_MD5;
      6'b000_010: decAlgo = ALG_SHA1;
      6'b000_100: decAlgo = ALG_SHA224;
      6'b000_101: decAlgo = ALG_SHA256;
      6'b000_110: decAlgo = ALG_SHA512;
      6'b001_110: decAlgo = ALG_SHA384;
      6'b010_110: decAlgo = ALG_SHA512T256;
      6'b011_110: decAlgo = ALG_SHA512T224;
      default:    cmdValid = 1'b0;
    endcase
  end

  assign finish = busyQ && engDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      startQ <= 1'b0;
      algoQ  <= ALG_MD5;
      sgQ    <= 1'b0;
      accQ   <= 1'b0;
      irqEnQ <= 1'b0;
    end else begin
      startQ <= 1'b0;
      if (strobe.cmdWr && !busyQ && cmdValid) begin
        startQ <= 1'b1;
        busyQ  <= 1'b1;
        algoQ  <= decAlgo;
        sgQ    <= strobe.sgEn;
        accQ   <= (strobe.mode == 2'b10);
        irqEnQ <= strobe.irqEn;
      end else if (finish) begin
        busyQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      irqQ  <= 1'b0;
    end else if (finish) begin
      doneQ <= 1'b1;
      if (irqEnQ) irqQ <= 1'b1;
    end else if (strobe.doneClr) begin
      doneQ <= 1'b0;
      irqQ  <= 1'b0;
    end
  end

  assign engStart = startQ;
  assign engAlgo  = algoQ;
  assign engSgEn  = sgQ;
  assign engAccum = accQ;
  assign doneFlag = doneQ;
  assign irqOut   = irqQ;

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ);
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmdWr && busyQ |=> !startQ);
  assert_invalid_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmdWr && !cmdValid |=> !startQ);
  assert_irq_needs_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> doneQ);
  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && engDone |=> doneQ && !busyQ);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doneClr && !(busyQ && engDone) |=> !doneQ && !irqQ);
endmodule

// File: rtl/hash_cmd_regs.sv
module hash_cmd_regs
  import hashctl_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int REG_W        = 32,
  parameter int WINDOW_BYTES = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              engDone,
  output logic              engStart,
  output logic [2:0]        engAlgo,
  output logic              engSgEn,
  output logic              engAccum,
  output logic [REG_W-1:0]  srcAddr,
  output logic [REG_W-1:0]  dstAddr,
  output logic [REG_W-1:0]  keyAddr,
  output logic [REG_W-1:0]  srcLen,
  output logic              irqOut
);
  ctlStrobe_t strobe;
  logic       doneFlag;

  hashctl_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .WINDOW_BYTES(WINDOW_BYTES)) uRegs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .doneFlag(doneFlag), .strobe(strobe),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .keyAddr(keyAddr), .srcLen(srcLen)
  );

  hashctl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .engDone(engDone),
    .engStart(engStart), .engAlgo(engAlgo), .engSgEn(engSgEn), .engAccum(engAccum),
    .doneFlag(doneFlag), .irqOut(irqOut)
  );
endmodule

// File: tb/hash_cmd_regs_test.sv
module hash_cmd_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engDone = 1'b0;
  logic        engStart, engSgEn, engAccum, irqOut;
  logic [2:0]  engAlgo;
  logic [31:0] srcAddr, dstAddr, keyAddr, srcLen;

  int nRun = 0;
  int nFail = 0;

  hash_cmd_regs uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    engDone = 1'b1;
    @(negedge clk);
    engDone = 1'b0;
  endtask

  function automatic logic expDecode(input logic [31:0] c, output logic [2:0] code);
    logic [2:0] fam = c[6:4];
    logic [2:0] sub = c[12:10];
    code = 3'd0;
    if (fam == 3'b110) begin
      code = 3'd4 + sub;
      return sub < 3'd4;
    end
    if (sub != 3'd0) return 1'b0;
    case (fam)
      3'b000: begin code = 3'd0; return 1'b1; end
      3'b010: begin code = 3'd1; return 1'b1; end
      3'b100: begin code = 3'd2; return 1'b1; end
      3'b101: begin code = 3'd3; return 1'b1; end
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [2:0]  code;
    logic        ok;
    logic [31:0] cmd;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    busRead(12'h30, rd); chk("R10 cmd", rd, 0);
    busRead(12'h1C, rd); chk("R10 status", rd, 0);
    busRead(12'h20, rd); chk("R10 src", rd, 0);
    chk("R10 irq", irqOut, 0);
    chk("R10 start", engStart, 0);

    // R1/R2 offsets and masks
    busWrite(12'h20, 32'hFFFFFFFF);
    busRead(12'h20, rd); chk("R2 src mask", rd, 32'h7FFFFFFF);
    busWrite(12'h24, 32'hFFFFFFFF);
    busRead(12'h24, rd); chk("R2 dst mask", rd, 32'h7FFFFFF8);
    busWrite(12'h28, 32'hFFFFFFFF);
    busRead(12'h28, rd); chk("R2 key mask", rd, 32'h7FFFFFF8);
    busWrite(12'h2C, 32'hFFFFFFFF);
    busRead(12'h2C, rd); chk("R2 len mask", rd, 32'h0FFFFFFF);
    chk("R2 srcAddr port", srcAddr, 32'h7FFFFFFF);
    chk("R2 dstAddr port", dstAddr, 32'h7FFFFFF8);
    chk("R2 keyAddr port", keyAddr, 32'h7FFFFFF8);
    chk("R2 srcLen port", srcLen, 32'h0FFFFFFF);
    busWrite(12'h24, 32'h1234_5677);
    busRead(12'h24, rd); chk("R1 dst readback", rd, 32'h1234_5670);
    busWrite(12'h10, 32'hA5A5_A5A5);
    chk("R1 cipher no start", engStart, 0);
    busRead(12'h10, rd); chk("R1 cipher readback", rd, 32'hA5A5_A5A5);

    // R9 window
    busWrite(12'h130, 32'h0000_0050);
    chk("R9 alias no start", engStart, 0);
    busRead(12'h30, rd); chk("R9 cmd untouched", rd, 0);
    busRead(12'h130, rd); chk("R9 read outside", rd, 0);
    busWrite(12'h34, 32'hFFFF_FFFF);
    busRead(12'h34, rd); chk("R9 read 0x34", rd, 0);
    busRead(12'h18, rd); chk("R9 unmapped word", rd, 0);
    busRead(12'h24, rd); chk("R9 dst untouched", rd, 32'h1234_5670);

    // R7 done while idle ignored
    pulseDone();
    busRead(12'h1C, rd); chk("R7 idle done ignored", rd, 0);

    // random commands R3 R4 R5 R6 R7 R8
    for (int t = 0; t < 80; t++) begin
      cmd = $urandom();
      cmd[6:4] = 3'($urandom_range(0, 7));
      cmd[12:10] = ($urandom_range(0, 1) == 1) ? 3'd0 : 3'($urandom_range(0, 7));
      ok = expDecode(cmd, code);
      busWrite(12'h30, cmd);
      chk("R6 start", engStart, 32'(ok));
      if (ok) begin
        chk("R3 algo", 32'(engAlgo), 32'(code));
        chk("R5 sg", engSgEn, cmd[18]);
        chk("R5 accum", engAccum, 32'(cmd[8:7] == 2'b10));
      end
      busRead(12'h30, rd); chk("R4 cmd stored", rd, cmd & 32'h00147FFF);
      chk("R6 single pulse", engStart, 0);
      if (ok) begin
        busWrite(12'h30, 32'h0000_0250);
        chk("R6 busy no restart", engStart, 0);
        if (t % 3 == 0) begin
          busWrite(12'h1C, 32'h0);
          busRead(12'h1C, rd); chk("R8 zero write busy", rd, 0);
        end
        pulseDone();
        busRead(12'h1C, rd); chk("R7 done flag", rd, 32'h200);
        chk("R7 irq", irqOut, cmd[9]);
        busWrite(12'h1C, 32'hFFFF_FDFF);
        busRead(12'h1C, rd); chk("R8 zero bit keeps", rd, 32'h200);
        busWrite(12'h1C, 32'h200);
        busRead(12'h1C, rd); chk("R8 clear", rd, 0);
        chk("R8 irq low", irqOut, 0);
      end
    end

    // R8 done and clear on the same edge
    busWrite(12'h30, 32'h0000_0260);
    chk("R6 start sha512", engStart, 1);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 12'h1C; busWdata = 32'h200; engDone = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; engDone = 1'b0;
    busRead(12'h1C, rd); chk("R8 done wins", rd, 32'h200);
    chk("R8 irq kept", irqOut, 1);

    // R10 reset while busy
    busWrite(12'h30, 32'h0000_0040);
    chk("R10 pre start", engStart, 1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busRead(12'h1C, rd); chk("R10 status cleared", rd, 0);
    chk("R10 irq cleared", irqOut, 0);
    busRead(12'h30, rd); chk("R10 cmd cleared", rd, 0);
    busRead(12'h24, rd); chk("R10 dst cleared", rd, 0);
    busWrite(12'h30, 32'h0000_0020);
    chk("R10 idle after reset", engStart, 1);
    chk("R3 sha1 code", 32'(engAlgo), 1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule